// File: doc/BRIEF.md
# Capture/Compare Timer with Infrared Carrier Gating

This block is a 16-bit up-counter with five capture/compare channels. The counter advances on ticks from a selectable clock divider and runs from zero up to a programmed period. When it wraps to zero it raises an overflow flag. Each channel holds a compare value. A channel either drives a pulse-width output that stays high while the count is below its compare value, or records the count when a selected edge appears on its input pin.

In infrared mode the counter no longer advances on divider ticks. Instead it steps once for each period pulse of a separate 8-bit carrier timer. Channel 0's output is then ANDed with the carrier waveform to give a modulated infrared drive. The carrier timer itself sits outside this block and supplies only its period pulse and its output level.

Software programs the block through a simple write port. Compare values are double-buffered, so a new value written while the counter runs cannot cut a pulse short.

Top module: `ir_cc_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag and all capture flags are 0, and every channel output and the infrared output are low.
- R2: The control register (address 0) holds the divider select in bits 1:0, run in bit 2 and infrared mode in bit 3. With run set and infrared mode clear, the count advances once every 1, 8, 32 or 128 clocks for select values 0, 1, 2 and 3.
- R3: The count steps from 0 up to the period value (address 1) and then returns to 0 on the next tick. That wrap sets the overflow flag. Writing a word with bit 5 set to address 12 clears the flag.
- R4: While run is clear the count holds its value.
- R5: Channel configuration lives at addresses 7 to 11, one per channel. Bit 0 selects capture (1) or pulse-width (0) mode. A pulse-width channel output is high exactly while the count is below the channel's active compare value, so a compare of 0 keeps it low. A capture-mode channel output is low.
- R6: Compare values are written to addresses 2 to 6, one per channel. A value written while run is set becomes active only at the next wrap. A value written while run is clear becomes active one clock after the write.
- R7: In capture mode, bits 2:1 of the channel configuration pick the edge: 1 for rising, 2 for falling, 3 for both, 0 for none. A picked edge on the pin latches the count into that channel's capture value and sets its capture flag. When the pin changes just before clock edge N+1, the flag and value appear after clock edge N+3, and the value is the count held between edges N+2 and N+3.
- R8: Writing to address 12 clears each capture flag whose bit (bits 4:0, channel order) is 1.
- R9: In infrared mode with run set, the count advances by one for each clock in which carrier_tick is high, and the divider select has no effect.
- R10: In infrared mode the infrared output equals channel 0's pulse-width output ANDed with carrier_out. Outside infrared mode the infrared output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| ch_in | input | 5 | Channel capture input pins |
| carrier_tick | input | 1 | One-clock pulse per carrier timer period |
| carrier_out | input | 1 | Carrier timer output level |
| ch_out | output | 5 | Channel pulse-width outputs |
| ir_out | output | 1 | Modulated infrared output |
| count_o | output | 16 | Current count |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 5 | Per-channel capture flags |
| cap_val | output | 80 | Captured counts, channel i in bits 16i+15:16i |

## Verification
The results have different latencies:
- The channel and infrared outputs are combinational from the count and the carrier level, so they are due in the same cycle as the count they depend on. The bench checks them after every clock against the observed count.
- A count step shows on count_o one clock after its tick.
- A compare written while stopped is active after one further edge. A compare written while running waits for the wrap that first shows count 0.
- A capture passes two synchroniser stages and one latch stage, so it is due three edges after the pin changes. The bench checks that the flag is still clear at two edges and set at three, with the value equal to the count seen two edges after the change.

All stimulus is driven and all outputs are sampled on the falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_t;

  typedef struct packed {
    edge_sel_t edge_sel;
    logic      cap_mode;
  } ch_cfg_t;

  // Clocks per count step for a divider select value.
  function automatic int unsigned div_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 128;
    endcase
  endfunction

  // Pulse-width level for a count against a compare value.
  function automatic logic pwm_level(input logic [15:0] cnt, input logic [15:0] cmp);
    return cnt < cmp;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ir_mode,
  input  logic [1:0] sel,
  input  logic       carrier_tick,
  output logic       tick
);
  import tmr_pkg::*;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(div_of(sel) - 1);
  assign tick  = run & (ir_mode ? carrier_tick : (pre_cnt >= limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pre_cnt <= '0;
    else if (!run || ir_mode || tick)  pre_cnt <= '0;
    else                               pre_cnt <= pre_cnt + 1'b1;
  end

  // R9: the divider stays cleared while carrier pulses drive the count
  p_ir_div_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ir_mode |=> (pre_cnt == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = tick && (count >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  // R4: no tick, no movement
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R3: a wrap lands on zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
  // R2: an ordinary tick steps by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (count == W'($past(count) + 1'b1)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  tmr_pkg::ch_cfg_t cfg_in,
  input  logic             cmp_we,
  input  logic [W-1:0]     cmp_in,
  input  logic             running,
  input  logic             wrap,
  input  logic [W-1:0]     count,
  input  logic             pin,
  input  logic             clr,
  output logic             pwm,
  output logic [W-1:0]     cap_val,
  output logic             cap_flag
);
  import tmr_pkg::*;

  ch_cfg_t      cfg;
  logic [W-1:0] cmp_sh, cmp_act;
  logic         s1, s2, s3;
  logic         rise, fall, hit;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign hit  = cfg.cap_mode &&
                ((rise && (cfg.edge_sel == EDGE_RISE || cfg.edge_sel == EDGE_BOTH)) ||
                 (fall && (cfg.edge_sel == EDGE_FALL || cfg.edge_sel == EDGE_BOTH)));
  assign pwm  = !cfg.cap_mode && pwm_level(16'(count), 16'(cmp_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      cmp_sh  <= '0;
      cmp_act <= '0;
    end else begin
      if (cfg_we)            cfg     <= cfg_in;
      if (cmp_we)            cmp_sh  <= cmp_in;
      if (!running || wrap)  cmp_act <= cmp_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      cap_val      <= '0;
      cap_flag     <= 1'b0;
    end else begin
      {s1, s2, s3} <= {pin, s1, s2};
      if (hit)      cap_val  <= count;
      if (hit)      cap_flag <= 1'b1;
      else if (clr) cap_flag <= 1'b0;
    end
  end

  // R6: the active compare cannot change in the middle of a running period
  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> $stable(cmp_act));
  // R7: a flag only rises after a qualifying edge
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(hit));
  // R7: the captured value is the count at the edge
  p_cap_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_val == $past(count)));

endmodule

// File: rtl/ir_cc_timer.sv
module ir_cc_timer #(
  parameter int CNT_W = 16,
  parameter int NCH   = 5,
  parameter int PRE_W = 7,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [NCH-1:0]     ch_in,
  input  logic               carrier_tick,
  input  logic               carrier_out,
  output logic [NCH-1:0]     ch_out,
  output logic               ir_out,
  output logic [CNT_W-1:0]   count_o,
  output logic               ovf_flag,
  output logic [NCH-1:0]     cap_flag,
  output logic [NCH*CNT_W-1:0] cap_val
);
  import tmr_pkg::*;

  localparam int A_CTRL = 0;
  localparam int A_PER  = 1;
  localparam int A_CMP0 = 2;
  localparam int A_CFG0 = A_CMP0 + NCH;
  localparam int A_CLR  = A_CFG0 + NCH;
  localparam int OVF_CLR_BIT = NCH;

  logic [3:0]       ctrl;
  logic [CNT_W-1:0] period;
  logic             tick, wrap;
  logic             run, ir_mode;
  logic             clr_we;

  assign run     = ctrl[2];
  assign ir_mode = ctrl[3];
  assign clr_we  = wr_en && (wr_addr == AW'(A_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      period <= '1;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) ctrl   <= wr_data[3:0];
      if (wr_addr == AW'(A_PER))  period <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ovf_flag <= 1'b0;
    else if (wrap)                            ovf_flag <= 1'b1;
    else if (clr_we && wr_data[OVF_CLR_BIT])  ovf_flag <= 1'b0;
  end

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .ir_mode(ir_mode),
    .sel(ctrl[1:0]), .carrier_tick(carrier_tick), .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .count(count_o), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(wr_en && (wr_addr == AW'(A_CFG0 + i))),
      .cfg_in(ch_cfg_t'(wr_data[2:0])),
      .cmp_we(wr_en && (wr_addr == AW'(A_CMP0 + i))),
      .cmp_in(wr_data),
      .running(run), .wrap(wrap), .count(count_o),
      .pin(ch_in[i]), .clr(clr_we && wr_data[i]),
      .pwm(ch_out[i]),
      .cap_val(cap_val[CNT_W*i +: CNT_W]),
      .cap_flag(cap_flag[i])
    );
  end

  assign ir_out = ir_mode & ch_out[0] & carrier_out;

  // R10: a modulated pulse only exists under the carrier in infrared mode
  p_ir_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ir_out |-> (carrier_out && ir_mode));
  // R3: the overflow flag only rises on a wrap
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wrap));

endmodule

// File: tb/tb_ir_cc_timer.sv
module tb_ir_cc_timer;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [4:0]  ch_in = 0;
  logic        carrier_tick = 0, carrier_out = 1;
  logic [4:0]  ch_out, cap_flag;
  logic        ir_out, ovf_flag;
  logic [15:0] count_o;
  logic [79:0] cap_val;

  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ir_cc_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch_in(ch_in), .carrier_tick(carrier_tick), .carrier_out(carrier_out),
    .ch_out(ch_out), .ir_out(ir_out), .count_o(count_o), .ovf_flag(ovf_flag),
    .cap_flag(cap_flag), .cap_val(cap_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [15:0] cval(input int ch);
    return cap_val[16*ch +: 16];
  endfunction

  task automatic t_reset();  // R1
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(ovf_flag == 0 && cap_flag == 0, "R1 flags", {ovf_flag, cap_flag}, 0);
    chk(ch_out == 0 && ir_out == 0, "R1 outputs", {ir_out, ch_out}, 0);
  endtask

  task automatic measure(input logic [1:0] sel, input int exp_div);  // R2
    int prev, n;
    wr(4'd0, {12'd0, 2'b01, sel});
    @(negedge clk); prev = count_o;
    while (count_o == prev) @(negedge clk);
    prev = count_o; n = 0;
    do begin @(negedge clk); n++; end while (count_o == prev && n < 1000);
    chk(n == exp_div, "R2 divider", n, exp_div);
  endtask

  task automatic t_divider();
    measure(2'd0, 1); measure(2'd1, 8); measure(2'd2, 32); measure(2'd3, 128);
  endtask

  task automatic t_wrap();  // R3, R4
    int prev, bad, c;
    bad = 0;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd5);
    wr(4'd0, 16'h0004);
    @(negedge clk); prev = count_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (prev >= 5 ? count_o != 0 : count_o != prev + 1) bad++;
      prev = count_o;
    end
    chk(bad == 0, "R3 sequence 0..period", bad, 0);
    chk(ovf_flag == 1, "R3 overflow set", ovf_flag, 1);
    wr(4'd0, 16'h0000);
    c = count_o;
    repeat (10) @(negedge clk);
    chk(count_o == c, "R4 hold when stopped", count_o, c);
    wr(4'd12, 16'h0020);
    chk(ovf_flag == 0, "R3 overflow cleared", ovf_flag, 1'b0);
  endtask

  task automatic t_pwm();  // R5, R6, R10
    int bad, zbad, phase, c;
    bad = 0; zbad = 0; phase = 0;
    wr(4'd1, 16'd9);
    wr(4'd2, 16'd4);
    wr(4'd3, 16'd0);
    wr(4'd9, 16'd1);
    wr(4'd0, 16'h0004);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ch_out[0] != (count_o < 4)) bad++;
      if (ch_out[1] || ch_out[2] || ir_out) zbad++;
    end
    chk(bad == 0, "R5 pwm level", bad, 0);
    chk(zbad == 0, "R5/R10 low outputs", zbad, 0);
    // R6: rewrite while running
    while (count_o != 2) @(negedge clk);
    wr(4'd2, 16'd8);
    bad = 0;
    for (int i = 0; i < 25; i++) begin
      if (count_o == 0) phase = 1;
      if (ch_out[0] != (count_o < (phase ? 8 : 4))) bad++;
      @(negedge clk);
    end
    chk(bad == 0 && phase == 1, "R6 update at wrap", bad, 0);
    // R6: rewrite while stopped
    wr(4'd0, 16'h0000);
    c = count_o;
    wr(4'd2, 16'(c + 1));
    @(negedge clk);
    chk(ch_out[0] == 1, "R6 stopped update high", ch_out[0], 1);
    wr(4'd2, 16'(c));
    @(negedge clk);
    chk(ch_out[0] == 0, "R6 stopped update low", ch_out[0], 0);
  endtask

  task automatic t_capture();  // R7, R8
    int c;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'hFFFF);
    wr(4'd10, 16'd3);
    wr(4'd11, 16'd5);
    repeat (5) @(negedge clk);
    c = count_o;
    ch_in = 5'b11000;
    repeat (4) @(negedge clk);
    chk(cap_flag[3] == 1 && cval(3) == c, "R7 rising capture", cval(3), c);
    chk(cap_flag[4] == 0, "R7 falling-only ignores rise", cap_flag[4], 0);
    ch_in = 5'b00000;
    repeat (4) @(negedge clk);
    chk(cap_flag[4] == 1 && cval(4) == c, "R7 falling capture", cval(4), c);
    wr(4'd12, 16'h0018);
    chk(cap_flag == 0, "R8 flag clear", cap_flag, 0);
    wr(4'd0, 16'h0004);
    @(negedge clk);
    c = count_o;
    ch_in[3] = 1;
    @(negedge clk); @(negedge clk);
    chk(cap_flag[3] == 0, "R7 not before three edges", cap_flag[3], 0);
    @(negedge clk);
    chk(cap_flag[3] == 1 && cval(3) == c + 2, "R7 latency value", cval(3), c + 2);
    ch_in[3] = 0;
  endtask

  task automatic t_ir();  // R9, R10
    int prev, exp, bad_hold, bad_gate;
    bad_hold = 0; bad_gate = 0;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd3);
    wr(4'd2, 16'd2);
    wr(4'd0, 16'h000F);
    for (int i = 0; i < 12; i++) begin
      prev = count_o;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        carrier_out = ~carrier_out;
        #1;
        if (count_o != prev) bad_hold++;
        if (ir_out != ((count_o < 2) && carrier_out)) bad_gate++;
      end
      exp = (prev >= 3) ? 0 : prev + 1;
      @(negedge clk); carrier_tick = 1;
      @(negedge clk); carrier_tick = 0;
      chk(count_o == exp, "R9 step per carrier tick", count_o, exp);
    end
    chk(bad_hold == 0, "R9 divider ignored", bad_hold, 0);
    chk(bad_gate == 0, "R10 gated output", bad_gate, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_wrap();
    t_pwm();
    t_capture();
    t_ir();
    finish_run();
  end
endmodule